// File: doc/BRIEF.md
# Word-Packing Receive Buffer

This block sits after a serial receiver that delivers one byte at a time on a valid/data pair. It gathers the bytes into 32-bit words in little-endian order and queues each complete word in a small word FIFO. Software reads the FIFO through a register port. A partial word of one to three bytes stays in the packing buffer, where software sees only its byte count, until a force-stale command flushes it into the FIFO early.

Software drives the block through five word-indexed registers on `reg_addr`:

| Index | Register | Access |
|-------|----------|--------|
| 0 | status | read |
| 1 | command | write |
| 2 | packing count | read |
| 3 | receive word | read |
| 4 | byte budget | read and write |

A byte budget limits how many bytes the current transfer accepts. Software rearms it after each flush. When the FIFO and the packing buffer are both full, an incoming byte is dropped and the overrun flag is raised. A command clears that flag.

Top module: `rx_word_packer`

## Requirements
- R1: After reset, the status register reads 0x4 (only bit 2, stale enabled, is set). The packing-count register reads 0 and the receive-word register reads 0.
- R2: Bytes are packed little-endian. The first byte of a word lands in bits [7:0] and each later byte lands in the next higher byte lane.
- R3: A complete four-byte word enters the FIFO on the clock edge after the fourth byte is accepted. Status bit 0 is 1 exactly while the FIFO holds at least one word.
- R4: Packing-count register bits [9:7] give the number of bytes in the packing buffer, from 0 to 4. All other bits of that register read 0.
- R5: Writing code 4 to command bits [11:8] (force stale) moves a partial word of 1 to 3 bytes into the FIFO, with its unused upper bytes zero, and the packing count drops to 0. With an empty packing buffer, no word is pushed.
- R6: Status bit 1 (stale pending) is set by force stale while status bit 2 (stale enabled) is 1. Code 8 in command bits [7:4] clears bit 1. Code 6 in command bits [11:8] clears bit 2. After that, force stale still flushes but no longer sets bit 1.
- R7: A byte that arrives while the FIFO is full and the packing buffer holds four bytes is dropped, and status bit 4 (overrun) is set. Code 3 in command bits [7:4] clears bit 4.
- R8: A full word held in the packing buffer enters the FIFO in the same cycle that a read frees a FIFO slot.
- R9: A read of the receive-word register pops exactly one word, oldest first. A read while the FIFO is empty returns 0 and changes nothing.
- R10: A write to the byte-budget register loads the budget, and a read returns the remaining count. Each accepted byte decrements the budget. While it is 0, incoming bytes are dropped without raising overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the FIFO when it addresses the receive-word register |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
The bench builds the block with a two-word FIFO and keeps the 16-bit budget. With a two-word FIFO, twelve bytes are enough to fill both the FIFO and the packing buffer. That makes the overrun drop and the refill-on-read path reachable in a short directed sequence. The budget register is loaded with small values so that the zero-budget drop is hit within a few bytes.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 3'd0,
        REG_CMD    = 3'd1,
        REG_PACK   = 3'd2,
        REG_RXWORD = 3'd3,
        REG_BUDGET = 3'd4
    } reg_idx_e;

    // command codes, low field [7:4] and high field [11:8]
    localparam logic [3:0] LO_CLR_OVR   = 4'd3;
    localparam logic [3:0] LO_CLR_STALE = 4'd8;
    localparam logic [3:0] HI_FORCE     = 4'd4;
    localparam logic [3:0] HI_STALE_OFF = 4'd6;

    localparam int ST_READY    = 0;
    localparam int ST_STALE    = 1;
    localparam int ST_STALE_EN = 2;
    localparam int ST_OVR      = 4;
    localparam int PACK_LSB    = 7;

    localparam int LANES  = 4;
    localparam int CNT_W  = 3;

endpackage

// File: rtl/rxpk_word_fifo.sv
module rxpk_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign count = st_q.cnt;
    assign head  = mem_q[st_q.rd_ptr];

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        if (push_ok) begin
            st_d.wr_ptr = (st_q.wr_ptr == AW'(DEPTH - 1)) ? '0 : st_q.wr_ptr + AW'(1);
        end
        if (pop_ok) begin
            st_d.rd_ptr = (st_q.rd_ptr == AW'(DEPTH - 1)) ? '0 : st_q.rd_ptr + AW'(1);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[st_q.wr_ptr] <= push_data;
        end
    end

endmodule

// File: rtl/rxpk_pack_core.sv
module rxpk_pack_core
    import rxpk_pkg::*;
#(
    parameter int              BUDGET_W   = 16,
    parameter logic [BUDGET_W-1:0] BUDGET_RST = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [7:0]          in_byte,
    input  logic                do_force,
    input  logic                do_stale_off,
    input  logic                do_clr_stale,
    input  logic                do_clr_ovr,
    input  logic                do_load,
    input  logic [BUDGET_W-1:0] load_val,
    input  logic                fifo_space,
    output logic                word_push,
    output logic [31:0]         word_data,
    output logic [CNT_W-1:0]    pack_cnt,
    output logic                ovr_flag,
    output logic                stale_flag,
    output logic                stale_en,
    output logic [BUDGET_W-1:0] budget
);
    typedef struct packed {
        logic [LANES-1:0][7:0] lanes;
        logic [CNT_W-1:0]      cnt;
        logic [BUDGET_W-1:0]   budget;
        logic                  ovr;
        logic                  stale;
        logic                  stale_en;
    } core_st_t;

    core_st_t st_d, st_q;

    assign pack_cnt   = st_q.cnt;
    assign ovr_flag   = st_q.ovr;
    assign stale_flag = st_q.stale;
    assign stale_en   = st_q.stale_en;
    assign budget     = st_q.budget;

    always_comb begin
        st_d      = st_q;
        word_push = 1'b0;
        word_data = '0;

        // hand a buffered word to the FIFO: full word first, else a flush
        if (st_q.cnt == CNT_W'(LANES) && fifo_space) begin
            word_push  = 1'b1;
            word_data  = st_q.lanes;
            st_d.cnt   = '0;
            st_d.lanes = '0;
        end else if (do_force && st_q.cnt != '0 && st_q.cnt != CNT_W'(LANES) && fifo_space) begin
            word_push  = 1'b1;
            word_data  = st_q.lanes;
            st_d.cnt   = '0;
            st_d.lanes = '0;
        end

        if (do_clr_stale) st_d.stale = 1'b0;
        if (do_force && st_q.stale_en) st_d.stale = 1'b1;
        if (do_stale_off) st_d.stale_en = 1'b0;
        if (do_clr_ovr) st_d.ovr = 1'b0;
        if (do_load) st_d.budget = load_val;

        if (in_valid && st_d.budget != '0) begin
            if (st_d.cnt == CNT_W'(LANES)) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.lanes[st_d.cnt[1:0]] = in_byte;
                st_d.cnt    = st_d.cnt + CNT_W'(1);
                st_d.budget = st_d.budget - BUDGET_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.budget   <= BUDGET_RST;
            st_q.stale_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
    import rxpk_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int BUDGET_W   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam int FCW = $clog2(FIFO_DEPTH) + 1;

    logic                cmd_wr, force_stale, stale_off, clr_stale, clr_ovr;
    logic                budget_wr, word_pop, fifo_space;
    logic                word_push, fifo_empty, fifo_full;
    logic [31:0]         word_data, fifo_head;
    logic [FCW-1:0]      fifo_count;
    logic [CNT_W-1:0]    pack_cnt;
    logic                ovr_flag, stale_flag, stale_en;
    logic [BUDGET_W-1:0] budget;

    always_comb begin
        cmd_wr      = reg_wr && (reg_addr == REG_CMD);
        force_stale = cmd_wr && (reg_wdata[11:8] == HI_FORCE);
        stale_off   = cmd_wr && (reg_wdata[11:8] == HI_STALE_OFF);
        clr_stale   = cmd_wr && (reg_wdata[7:4] == LO_CLR_STALE);
        clr_ovr     = cmd_wr && (reg_wdata[7:4] == LO_CLR_OVR);
        budget_wr   = reg_wr && (reg_addr == REG_BUDGET);
        word_pop    = reg_rd && (reg_addr == REG_RXWORD);
        fifo_space  = !fifo_full || word_pop;
    end

    rxpk_pack_core #(
        .BUDGET_W   (BUDGET_W),
        .BUDGET_RST ({BUDGET_W{1'b1}})
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (rx_valid),
        .in_byte      (rx_byte),
        .do_force     (force_stale),
        .do_stale_off (stale_off),
        .do_clr_stale (clr_stale),
        .do_clr_ovr   (clr_ovr),
        .do_load      (budget_wr),
        .load_val     (reg_wdata[BUDGET_W-1:0]),
        .fifo_space   (fifo_space),
        .word_push    (word_push),
        .word_data    (word_data),
        .pack_cnt     (pack_cnt),
        .ovr_flag     (ovr_flag),
        .stale_flag   (stale_flag),
        .stale_en     (stale_en),
        .budget       (budget)
    );

    rxpk_word_fifo #(
        .WIDTH (32),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (word_push),
        .push_data (word_data),
        .pop       (word_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_count)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_STATUS: begin
                reg_rdata[ST_READY]    = !fifo_empty;
                reg_rdata[ST_STALE]    = stale_flag;
                reg_rdata[ST_STALE_EN] = stale_en;
                reg_rdata[ST_OVR]      = ovr_flag;
            end
            REG_PACK:   reg_rdata[PACK_LSB +: CNT_W] = pack_cnt;
            REG_RXWORD: reg_rdata = fifo_empty ? '0 : fifo_head;
            REG_BUDGET: reg_rdata[BUDGET_W-1:0] = budget;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rx_word_packer_chk.sv
module rx_word_packer_chk #(
    parameter int FIFO_DEPTH = 8,
    parameter int FCW        = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rx_valid,
    input logic           force_stale,
    input logic           word_pop,
    input logic           word_push,
    input logic           fifo_full,
    input logic [FCW-1:0] fifo_count,
    input logic [2:0]     pack_cnt,
    input logic           ovr_flag
);
    // R4
    pack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pack_cnt <= 3'd4);

    // R3
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= FCW'(FIFO_DEPTH));

    // R7
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(rx_valid));

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_pop && fifo_count == '0 && !word_push) |=> fifo_count == '0);

    // R5
    stale_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stale && pack_cnt != 3'd0 && pack_cnt != 3'd4 && !fifo_full && !rx_valid)
        |=> pack_cnt == 3'd0);

    // R8
    held_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pack_cnt == 3'd4 && fifo_full && word_pop) |=> (fifo_count == FCW'(FIFO_DEPTH)));

endmodule

bind rx_word_packer rx_word_packer_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .FCW        (FCW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .force_stale (force_stale),
    .word_pop    (word_pop),
    .word_push   (word_push),
    .fifo_full   (fifo_full),
    .fifo_count  (fifo_count),
    .pack_cnt    (pack_cnt),
    .ovr_flag    (ovr_flag)
);

// File: tb/rx_word_packer_tb.sv
module rx_word_packer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    rx_word_packer #(.FIFO_DEPTH(2), .BUDGET_W(16)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    typedef struct packed {
        logic [2:0]  nbytes;
        logic [31:0] bytes;
        logic [31:0] expect_word;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{3'd4, 32'h44332211, 32'h44332211},
        '{3'd1, 32'hDEADBE5A, 32'h0000005A},
        '{3'd2, 32'hFFFFC3B7, 32'h0000C3B7},
        '{3'd3, 32'h99807060, 32'h00807060},
        '{3'd4, 32'h01FF807F, 32'h01FF807F}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd   = 1'b1;
        reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(3'd0, v); check("R1 status", v, 32'h4);
        rd_reg(3'd2, v); check("R1 pack count", v, 32'h0);
        // R9 empty read returns zero and changes nothing
        rd_reg(3'd3, v); check("R1 R9 empty rxword", v, 32'h0);
        rd_reg(3'd0, v); check("R9 status after empty read", v, 32'h4);

        // R2 R5 vector table
        foreach (VECS[k]) begin
            for (int j = 0; j < int'(VECS[k].nbytes); j++) send_byte(VECS[k].bytes[8*j +: 8]);
            if (VECS[k].nbytes < 3'd4) wr_reg(3'd1, 32'h400);
            else idle(1);
            rd_reg(3'd2, v); check("R5 R3 pack count zero", v, 32'h0);
            rd_reg(3'd0, v); check("R3 ready set", {31'd0, v[0]}, 32'h1);
            rd_reg(3'd3, v); check("R2 R5 word value", v, VECS[k].expect_word);
            rd_reg(3'd0, v); check("R3 ready cleared", {31'd0, v[0]}, 32'h0);
            wr_reg(3'd1, 32'h80);
        end

        // R4 partial count field
        send_byte(8'hA0); send_byte(8'hA1); send_byte(8'hA2);
        rd_reg(3'd2, v); check("R4 three bytes", v, 32'h180);
        rd_reg(3'd0, v); check("R4 partial not ready", {31'd0, v[0]}, 32'h0);

        // R6 stale flag set and cleared
        wr_reg(3'd1, 32'h400);
        rd_reg(3'd0, v); check("R6 stale set", v, 32'h7);
        wr_reg(3'd1, 32'h80);
        rd_reg(3'd0, v); check("R6 stale cleared", v, 32'h5);
        rd_reg(3'd3, v); check("R2 flushed three", v, 32'h00A2A1A0);

        // R5 force stale on empty buffer pushes nothing
        wr_reg(3'd1, 32'h400);
        rd_reg(3'd0, v); check("R5 empty flush no word", {31'd0, v[0]}, 32'h0);
        wr_reg(3'd1, 32'h80);

        // R6 disable: flush still works, flag stays clear
        wr_reg(3'd1, 32'h600);
        rd_reg(3'd0, v); check("R6 stale disabled", v, 32'h0);
        send_byte(8'h3C);
        wr_reg(3'd1, 32'h400);
        rd_reg(3'd0, v); check("R6 flush without flag", v, 32'h1);
        rd_reg(3'd3, v); check("R6 flushed word", v, 32'h0000003C);

        // R7 R8 fill FIFO and packing buffer, then overrun
        for (int j = 0; j < 12; j++) send_byte(8'h10 + 8'(j));
        idle(1);
        rd_reg(3'd2, v); check("R4 held four", v, 32'h200);
        send_byte(8'hEE);
        rd_reg(3'd0, v); check("R7 overrun set", v, 32'h11);
        rd_reg(3'd2, v); check("R7 dropped byte", v, 32'h200);
        rd_reg(3'd3, v); check("R9 first word", v, 32'h13121110);
        rd_reg(3'd2, v); check("R8 held word moved", v, 32'h0);
        rd_reg(3'd3, v); check("R9 second word", v, 32'h17161514);
        rd_reg(3'd3, v); check("R8 R7 third word", v, 32'h1B1A1918);
        rd_reg(3'd3, v); check("R9 drained", v, 32'h0);
        wr_reg(3'd1, 32'h30);
        rd_reg(3'd0, v); check("R7 overrun cleared", v, 32'h0);

        // R10 byte budget
        wr_reg(3'd4, 32'h2);
        rd_reg(3'd4, v); check("R10 budget loaded", v, 32'h2);
        send_byte(8'h51); send_byte(8'h52); send_byte(8'h53);
        rd_reg(3'd2, v); check("R10 only two accepted", v, 32'h100);
        rd_reg(3'd4, v); check("R10 budget exhausted", v, 32'h0);
        rd_reg(3'd0, v); check("R10 no overrun", v, 32'h0);
        wr_reg(3'd1, 32'h400);
        rd_reg(3'd3, v); check("R10 flushed word", v, 32'h00005251);
        wr_reg(3'd4, 32'h7);
        rd_reg(3'd4, v); check("R10 rearmed", v, 32'h7);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule